// File: doc/BRIEF.md
# Common-Mode-Free Vector Translator for a Dual Two-Level Inverter

This block sits between a space-vector modulator and the gate drivers of two two-level inverters that feed the two ends of an open-end three-phase winding from one shared DC link. The modulator computes a switching state for the first inverter only. It presents that state as three leg bits, together with a one-hot flag that names the phase holding the middle reference value. The block turns each such state into a pair of states, one per inverter. It uses only the odd states 1, 3 and 5 on either side, so neither inverter's own common-mode voltage ever alternates.

Each of the six active states of the first inverter maps to a fixed pair. A zero state (all legs high or all legs low) maps to a repeated odd state that depends on which phase is in the middle. Because of this choice, one inverter stays clamped to a single state for the whole of a sector while the other inverter switches. All six pole commands and both decoded state indices are registered together, so both inverters change on the same clock edge.

State numbering used throughout, as upper-switch bits for phases A, B, C: 1=(1,0,0), 2=(1,1,0), 3=(0,1,0), 4=(0,1,1), 5=(0,0,1), 6=(1,0,1), 7=(1,1,1), 8=(0,0,0). On every three-bit bus, bit 0 is phase A, bit 1 is phase B and bit 2 is phase C.

Top module: `cmfree_vec_xlat`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, both state indices read RST_STATE (default 1), both pole buses read the legs of that state (001 by default), and `mid_err` is 0. Reset is asynchronous.
- R2: When the leg input decodes to an active state, the output pair (primary, secondary) becomes 1→(1,3), 2→(1,5), 3→(3,5), 4→(3,1), 5→(5,1), 6→(5,3).
- R3: When the leg input is a zero state (111 or 000) and `mid_flag` is 3'b010 (phase B in the middle), the output pair becomes (1,1).
- R4: When the leg input is a zero state and `mid_flag` is 3'b001 (phase A), the pair becomes (3,3). With `mid_flag` 3'b100 (phase C), it becomes (5,5).
- R5: Both state indices only ever take the values 1, 3 or 5.
- R6: When a zero state arrives with a `mid_flag` that is not one-hot, both state indices and both pole buses hold their previous values, and `mid_err` is 1 for that cycle. A later valid request clears `mid_err`.
- R7: `mid_flag` has no effect while the leg input is an active state, even when the flag is not one-hot. In that case `mid_err` is 0.
- R8: Outputs change exactly one clock edge after the inputs are sampled, and both inverters' poles change on that same edge.
- R9: Each pole bus equals the legs of its state index: 1→001, 3→010, 5→100.
- R10: Each pole bus always has exactly one leg high, so each inverter's common-mode level is constant.
- R11: Within a sector, holding the mid flag fixed while the modulator uses the sector's two active states and a zero state keeps one inverter at a single state. Examples: states 1, 2 and zero with B in the middle keep the primary at 1. States 4, 5 and zero with B keep the secondary at 1. States 3, 4 and zero with A keep the primary at 3. States 6, 1 and zero with A keep the secondary at 3. States 5, 6 and zero with C keep the primary at 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv1_leg | input | 3 | Modulator leg bits for the first inverter (bit 0 = A) |
| mid_flag | input | 3 | One-hot middle-phase flag (bit 0 = A, 1 = B, 2 = C) |
| pole_pri | output | 3 | Registered pole commands of the first inverter |
| pole_sec | output | 3 | Registered pole commands of the second inverter |
| st_pri | output | 4 | Registered state index of the first inverter |
| st_sec | output | 4 | Registered state index of the second inverter |
| mid_err | output | 1 | Zero state requested with a non-one-hot mid flag |

## Verification
The bench steps through every sector with its two active states and both zero codes. A swapped entry in the active table, or a zero pair tied to the wrong middle phase, shows up as a wrong pair and breaks the clamping of one inverter across the sector. Malformed mid flags are sent during active states, where a design that looked at them would raise a false error. They are also sent during zero states, where a design that did not hold would jump to an arbitrary pair, possibly an even state. Latency is probed just before and just after the capturing edge, and reset is also applied mid-run, so a design with an extra stage or a synchronous-only reset is caught.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

   localparam int unsigned CMX_PHASES = 3;
   localparam int unsigned CMX_IDX_W  = 4;
   localparam int unsigned CMX_NACT   = 6;

   typedef logic [CMX_IDX_W-1:0]  st_idx_t;
   typedef logic [CMX_PHASES-1:0] leg_t;

   typedef struct packed {
      st_idx_t pri;
      st_idx_t sec;
   } st_pair_t;

   // Leg bits (bit0 = A) to state index 1..8.
   function automatic st_idx_t leg_to_idx(input leg_t leg);
      st_idx_t r;
      case (leg)
         3'b001:  r = st_idx_t'(1);
         3'b011:  r = st_idx_t'(2);
         3'b010:  r = st_idx_t'(3);
         3'b110:  r = st_idx_t'(4);
         3'b100:  r = st_idx_t'(5);
         3'b101:  r = st_idx_t'(6);
         3'b111:  r = st_idx_t'(7);
         default: r = st_idx_t'(8);
      endcase
      return r;
   endfunction

   // State index to leg bits (inverse of leg_to_idx).
   function automatic leg_t idx_to_leg(input st_idx_t idx);
      leg_t r;
      case (idx)
         st_idx_t'(1): r = 3'b001;
         st_idx_t'(2): r = 3'b011;
         st_idx_t'(3): r = 3'b010;
         st_idx_t'(4): r = 3'b110;
         st_idx_t'(5): r = 3'b100;
         st_idx_t'(6): r = 3'b101;
         st_idx_t'(7): r = 3'b111;
         default:      r = 3'b000;
      endcase
      return r;
   endfunction

   // Primary inverter state for an active state: round down to the odd state.
   function automatic st_idx_t pri_of(input st_idx_t idx);
      int unsigned k;
      k = int'(idx);
      if ((k % 2) == 0) k = k - 1;
      return st_idx_t'(k);
   endfunction

   // Secondary inverter state: odd k -> k+2, even k -> k+3, wrapped to 1..6.
   function automatic st_idx_t sec_of(input st_idx_t idx);
      int unsigned k;
      k = int'(idx);
      k = k + (((k % 2) == 1) ? 2 : 3);
      if (k > CMX_NACT) k = k - CMX_NACT;
      return st_idx_t'(k);
   endfunction

endpackage

// File: rtl/cmx_leg_decode.sv
module cmx_leg_decode
   import cmx_pkg::*;
#(
   parameter int unsigned PHASES = CMX_PHASES
) (
   input  logic [PHASES-1:0] leg,
   output st_idx_t           idx,
   output logic              is_zero
);

   always_comb begin
      idx     = leg_to_idx(leg);
      is_zero = (&leg) | (~|leg);
   end

endmodule

// File: rtl/cmx_pair_map.sv
module cmx_pair_map
   import cmx_pkg::*;
#(
   parameter int unsigned PHASES = CMX_PHASES
) (
   input  st_idx_t           idx,
   input  logic              is_zero,
   input  logic [PHASES-1:0] mid,
   output st_pair_t          pair,
   output logic              ok
);

   st_idx_t zero_cand [PHASES];
   st_idx_t zero_st;
   logic    mid_one;

   // Middle phase A -> 3, B -> 1, C -> 5.
   for (genvar k = 0; k < PHASES; k++) begin : g_zsel
      localparam st_idx_t ZST = st_idx_t'(((4 - k) % 3) * 2 + 1);
      assign zero_cand[k] = mid[k] ? ZST : '0;
   end

   always_comb begin
      zero_st = '0;
      for (int k = 0; k < PHASES; k++) zero_st = zero_st | zero_cand[k];
      mid_one = $onehot(mid);
   end

   always_comb begin
      if (is_zero) begin
         pair.pri = zero_st;
         pair.sec = zero_st;
         ok       = mid_one;
      end else begin
         pair.pri = pri_of(idx);
         pair.sec = sec_of(idx);
         ok       = 1'b1;
      end
   end

endmodule

// File: rtl/cmx_pole_out.sv
module cmx_pole_out
   import cmx_pkg::*;
#(
   parameter int unsigned PHASES    = CMX_PHASES,
   parameter int unsigned RST_STATE = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  st_pair_t            pair_nxt,
   input  logic                ok,
   output st_pair_t            pair_q,
   output logic                err_q,
   output logic [2*PHASES-1:0] poles
);

   localparam st_idx_t RST_IDX = st_idx_t'(RST_STATE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pair_q.pri <= RST_IDX;
         pair_q.sec <= RST_IDX;
         err_q      <= 1'b0;
      end else begin
         if (ok) pair_q <= pair_nxt;
         err_q <= ~ok;
      end
   end

   // One pole encoder per inverter; g=0 primary, g=1 secondary.
   for (genvar g = 0; g < 2; g++) begin : g_enc
      st_idx_t sel;
      assign sel = (g == 0) ? pair_q.pri : pair_q.sec;
      assign poles[g*PHASES +: PHASES] = idx_to_leg(sel);
   end

endmodule

// File: rtl/cmfree_vec_xlat.sv
module cmfree_vec_xlat
   import cmx_pkg::*;
#(
   parameter int unsigned PHASES    = CMX_PHASES,
   parameter int unsigned IDX_W     = CMX_IDX_W,
   parameter int unsigned RST_STATE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHASES-1:0] inv1_leg,
   input  logic [PHASES-1:0] mid_flag,
   output logic [PHASES-1:0] pole_pri,
   output logic [PHASES-1:0] pole_sec,
   output logic [IDX_W-1:0]  st_pri,
   output logic [IDX_W-1:0]  st_sec,
   output logic              mid_err
);

   localparam int unsigned POLE_W = 2 * PHASES;

   if (PHASES != 3) begin : g_bad_phases
      $error("cmfree_vec_xlat: PHASES must be 3");
   end
   if (IDX_W != CMX_IDX_W) begin : g_bad_idx
      $error("cmfree_vec_xlat: IDX_W must match the package index width");
   end
   if (RST_STATE != 1 && RST_STATE != 3 && RST_STATE != 5) begin : g_bad_rst
      $error("cmfree_vec_xlat: RST_STATE must be an odd active state");
   end

   st_idx_t          dec_idx;
   logic             dec_zero;
   st_pair_t         map_pair;
   logic             map_ok;
   st_pair_t         reg_pair;
   logic             reg_err;
   logic [POLE_W-1:0] reg_poles;

   cmx_leg_decode #(.PHASES(PHASES)) u_dec (
      .leg     (inv1_leg),
      .idx     (dec_idx),
      .is_zero (dec_zero)
   );

   cmx_pair_map #(.PHASES(PHASES)) u_map (
      .idx     (dec_idx),
      .is_zero (dec_zero),
      .mid     (mid_flag),
      .pair    (map_pair),
      .ok      (map_ok)
   );

   cmx_pole_out #(.PHASES(PHASES), .RST_STATE(RST_STATE)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .pair_nxt (map_pair),
      .ok       (map_ok),
      .pair_q   (reg_pair),
      .err_q    (reg_err),
      .poles    (reg_poles)
   );

   assign pole_pri = reg_poles[0 +: PHASES];
   assign pole_sec = reg_poles[PHASES +: PHASES];
   assign st_pri   = reg_pair.pri;
   assign st_sec   = reg_pair.sec;
   assign mid_err  = reg_err;

endmodule

// File: rtl/cmx_vec_xlat_chk.sv
module cmx_vec_xlat_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] inv1_leg,
   input logic [2:0] mid_flag,
   input logic [2:0] pole_pri,
   input logic [2:0] pole_sec,
   input logic [3:0] st_pri,
   input logic [3:0] st_sec,
   input logic       mid_err
);

   logic leg_zero;
   assign leg_zero = (inv1_leg == 3'b000) || (inv1_leg == 3'b111);

   // R5
   odd_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_pri == 4'd1 || st_pri == 4'd3 || st_pri == 4'd5) &&
      (st_sec == 4'd1 || st_sec == 4'd3 || st_sec == 4'd5));

   // R10
   cm_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pole_pri) == 1 && $countones(pole_sec) == 1);

   // R9
   idx_pole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pole_pri == 3'b001) == (st_pri == 4'd1) &&
      (pole_sec == 3'b100) == (st_sec == 4'd5));

   // R2
   act_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !leg_zero |=> st_pri != st_sec);

   // R7
   act_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !leg_zero |=> !mid_err);

   // R3
   zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (leg_zero && mid_flag == 3'b010) |=> (st_pri == 4'd1 && st_sec == 4'd1));

   // R4
   zero_ac_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (leg_zero && mid_flag == 3'b001) |=> (st_pri == 4'd3 && st_sec == 4'd3));

   // R6
   bad_mid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (leg_zero && !$onehot(mid_flag)) |=>
         (mid_err && $stable(st_pri) && $stable(st_sec) && $stable(pole_pri)));

endmodule

bind cmfree_vec_xlat cmx_vec_xlat_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .inv1_leg (inv1_leg),
   .mid_flag (mid_flag),
   .pole_pri (pole_pri),
   .pole_sec (pole_sec),
   .st_pri   (st_pri),
   .st_sec   (st_sec),
   .mid_err  (mid_err)
);

// File: tb/tb_cmfree_vec_xlat.sv
module tb_cmfree_vec_xlat;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] inv1_leg = 3'b110;
   logic [2:0] mid_flag = 3'b001;
   logic [2:0] pole_pri, pole_sec;
   logic [3:0] st_pri, st_sec;
   logic       mid_err;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cmfree_vec_xlat dut (
      .clk(clk), .rst_n(rst_n), .inv1_leg(inv1_leg), .mid_flag(mid_flag),
      .pole_pri(pole_pri), .pole_sec(pole_sec), .st_pri(st_pri),
      .st_sec(st_sec), .mid_err(mid_err)
   );

   // Entry: leg(3) mid(3) exp_pri(4) exp_sec(4) exp_err(1) tag(4)
   localparam logic [18:0] TBL [20] = '{
      {3'b001, 3'b010, 4'd1, 4'd3, 1'b0, 4'd2},
      {3'b011, 3'b010, 4'd1, 4'd5, 1'b0, 4'd11},
      {3'b000, 3'b010, 4'd1, 4'd1, 1'b0, 4'd3},
      {3'b110, 3'b010, 4'd3, 4'd1, 1'b0, 4'd2},
      {3'b100, 3'b010, 4'd5, 4'd1, 1'b0, 4'd11},
      {3'b111, 3'b010, 4'd1, 4'd1, 1'b0, 4'd3},
      {3'b010, 3'b001, 4'd3, 4'd5, 1'b0, 4'd2},
      {3'b110, 3'b001, 4'd3, 4'd1, 1'b0, 4'd11},
      {3'b111, 3'b001, 4'd3, 4'd3, 1'b0, 4'd4},
      {3'b101, 3'b001, 4'd5, 4'd3, 1'b0, 4'd2},
      {3'b001, 3'b001, 4'd1, 4'd3, 1'b0, 4'd11},
      {3'b000, 3'b001, 4'd3, 4'd3, 1'b0, 4'd4},
      {3'b100, 3'b100, 4'd5, 4'd1, 1'b0, 4'd2},
      {3'b101, 3'b100, 4'd5, 4'd3, 1'b0, 4'd11},
      {3'b111, 3'b100, 4'd5, 4'd5, 1'b0, 4'd4},
      {3'b011, 3'b000, 4'd1, 4'd5, 1'b0, 4'd7},
      {3'b010, 3'b111, 4'd3, 4'd5, 1'b0, 4'd7},
      {3'b000, 3'b000, 4'd3, 4'd5, 1'b1, 4'd6},
      {3'b111, 3'b011, 4'd3, 4'd5, 1'b1, 4'd6},
      {3'b000, 3'b100, 4'd5, 4'd5, 1'b0, 4'd6}
   };

   function automatic string tag_name(input int t);
      case (t)
         2:  return "R2";
         3:  return "R3";
         4:  return "R4";
         6:  return "R6";
         7:  return "R7";
         11: return "R11";
         default: return "R?";
      endcase
   endfunction

   function automatic logic [2:0] legs_of(input logic [3:0] s);
      case (s)
         4'd1:    return 3'b001;
         4'd3:    return 3'b010;
         4'd5:    return 3'b100;
         default: return 3'bxxx;
      endcase
   endfunction

   task automatic check_out(input string tag, input logic [3:0] ep,
                            input logic [3:0] es, input logic ee);
      n_chk++;
      if (st_pri !== ep || st_sec !== es || mid_err !== ee) begin
         n_fail++;
         $display("FAIL %s: st=(%0d,%0d) err=%0d expected st=(%0d,%0d) err=%0d",
                  tag, st_pri, st_sec, mid_err, ep, es, ee);
      end
      n_chk++;
      if (pole_pri !== legs_of(ep) || pole_sec !== legs_of(es)) begin
         n_fail++;
         $display("FAIL R5/R9/R10 (%s): poles=%b,%b expected %b,%b",
                  tag, pole_pri, pole_sec, legs_of(ep), legs_of(es));
      end
   endtask

   initial begin
      // R1: reset state, held across two edges while in reset
      repeat (2) @(negedge clk);
      check_out("R1", 4'd1, 4'd1, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // first edge after release captured s4/A -> (3,1); re-drive for R8 probe
      check_out("R2", 4'd3, 4'd1, 1'b0);

      // R8: output changes only on the capturing edge
      inv1_leg = 3'b001; mid_flag = 3'b010;
      #4;
      check_out("R8", 4'd3, 4'd1, 1'b0);
      #2;
      check_out("R8", 4'd1, 4'd3, 1'b0);

      // Table walk
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         inv1_leg = TBL[i][18:16];
         mid_flag = TBL[i][15:13];
         @(negedge clk);
         check_out(tag_name(int'(TBL[i][3:0])), TBL[i][12:9], TBL[i][8:5], TBL[i][4]);
      end

      // R6: repeated bad flag keeps holding
      inv1_leg = 3'b111; mid_flag = 3'b110;
      @(negedge clk);
      check_out("R6", 4'd5, 4'd5, 1'b1);

      // R1: asynchronous reset mid-run
      inv1_leg = 3'b010; mid_flag = 3'b001;
      @(negedge clk);
      check_out("R2", 4'd3, 4'd5, 1'b0);
      #2 rst_n = 1'b0;
      #1;
      check_out("R1", 4'd1, 4'd1, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      inv1_leg = 3'b000; mid_flag = 3'b100;
      @(negedge clk);
      check_out("R4", 4'd5, 4'd5, 1'b0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule